// File: doc/BRIEF.md
# Cascaded Multi-Digit Decimal Adder

This block adds two packed decimal operands of `DIGITS` digits each, plus a one-bit carry-in. It returns a packed decimal sum of the same width and a decimal carry-out. Each digit has its own slice, built in three stages:

- **Binary add.** A chain of four single-bit full cells adds the two input digits and the incoming carry.
- **Decimal carry.** A carry detector decides whether the binary result went past nine.
- **Correction.** A small network adds six to the digit when the decimal carry is set. It uses one XOR, one half cell and one full cell.

The decimal carry of each slice drives the carry-in of the slice above it. The external carry-in enters the lowest digit.

The block is combinational up to an optional output register that is enabled by default. Each digit also raises a flag when either operand digit is not a legal decimal digit. In that case the sum digit has no defined value.

Top module: `bcd_chain_adder`

## Requirements
- R1: With `REG_OUT`=1, a rising clock edge while `rst_n` is low sets `sum_o`, `cout_o` and `bad_digit_o` to zero.
- R2: When every operand digit is in 0..9, every digit of the sum is in 0..9.
- R3: The decimal carry out of digit k is 1 exactly when a_k + b_k + carry-in_k is greater than 9.
- R4: Let t be the 4-bit binary sum of a digit. The digit result is t when its decimal carry is 0, and (t + 6) mod 16 when its decimal carry is 1.
- R5: Carries chain through the digits as follows:
  - `cin_i` is the carry into digit 0.
  - The decimal carry of digit k is the carry into digit k+1.
  - `cout_o` is the decimal carry of the top digit.
  - For valid operands, {`cout_o`, `sum_o`} therefore equals the decimal value of a + b + `cin_i`.
- R6: Digit k of every packed operand and of the sum occupies bits [4k+3:4k]. Digit 0 is the least significant.
- R7: `bad_digit_o[k]` is 1 exactly when operand digit k of `a_i` or of `b_i` is in 10..15.
- R8: With `REG_OUT`=1, new inputs reach the outputs at the first rising edge after they are applied, and the outputs hold their old value until that edge. With `REG_OUT`=0, the outputs follow the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| a_i | input | 4*DIGITS | First packed decimal operand |
| b_i | input | 4*DIGITS | Second packed decimal operand |
| cin_i | input | 1 | Carry into the lowest digit |
| sum_o | output | 4*DIGITS | Packed decimal sum |
| cout_o | output | 1 | Decimal carry out of the top digit |
| bad_digit_o | output | DIGITS | Per-digit invalid-operand flag |

## Verification
The bench drives the adder with four kinds of input:

- **Fixed vectors.** These exercise the extremes of the carry chain: all-nines plus one with a ripple through every digit, a carry created in one digit and absorbed in the next, and an operand sum of exactly ten. They separate a wrong carry-propagation path from a wrong correction.
- **Random valid operands.** These are compared against integer decimal addition. They catch errors that depend on the mix of digits across the whole word.
- **Exhaustive single digit.** A one-digit instance is driven over every operand pair and both carry-in values. The sums of 10 through 19 isolate the detector and the correction constant, and the codes 10 through 15 isolate the invalid flag.
- **Reset and latency.** Directed steps confirm that reset clears the outputs and that results take exactly one register stage.

// File: rtl/bcd_pkg.sv
// Package bcd_pkg
// Shared widths and constants for the decimal adder.
// Assumes packed decimal digits of four bits each.
package bcd_pkg;
    localparam int unsigned DIGIT_W   = 4;
    localparam logic [3:0]  MAX_DIGIT = 4'd9;
    localparam logic [3:0]  ADJUST    = 4'd6;
    typedef logic [DIGIT_W-1:0] bcd_digit_t;
endpackage

// File: rtl/bcd_full_cell.sv
// Module bcd_full_cell
// One-bit full adder cell: sum and carry of three input bits.
// Assumes nothing beyond single-bit inputs.
module bcd_full_cell (
    input  logic x_i,
    input  logic y_i,
    input  logic z_i,
    output logic s_o,
    output logic co_o
);
    logic xy;

    // propagate term, sum and carry
    always_comb begin
        xy   = x_i ^ y_i;
        s_o  = xy ^ z_i;
        co_o = (xy & z_i) | (x_i & y_i);
    end
endmodule

// File: rtl/bcd_half_cell.sv
// Module bcd_half_cell
// One-bit half adder cell used in the correction network.
// Assumes two single-bit inputs.
module bcd_half_cell (
    input  logic x_i,
    input  logic y_i,
    output logic s_o,
    output logic co_o
);
    // sum and carry of two bits
    always_comb begin
        s_o  = x_i ^ y_i;
        co_o = x_i & y_i;
    end
endmodule

// File: rtl/bcd_digit_slice.sv
// Module bcd_digit_slice
// Adds one decimal digit pair plus a carry-in.
// Stage 1 ripples four full cells, stage 2 detects the decimal carry,
// stage 3 adds six when that carry is set.
// Assumes legal digits; illegal codes are only flagged.
module bcd_digit_slice
    import bcd_pkg::*;
(
    input  bcd_digit_t a_i,
    input  bcd_digit_t b_i,
    input  logic       cin_i,
    output bcd_digit_t digit_o,
    output logic       dcarry_o,
    output logic       bad_o
);
    logic [DIGIT_W:0]   rip;
    logic [DIGIT_W-1:0] bsum;
    logic               fix_c1;
    logic               fix_c2;
    logic               dcarry;

    assign rip[0] = cin_i;

    // stage 1: binary ripple of four full cells
    for (genvar i = 0; i < DIGIT_W; i++) begin : g_rip
        bcd_full_cell u_fa (
            .x_i (a_i[i]),
            .y_i (b_i[i]),
            .z_i (rip[i]),
            .s_o (bsum[i]),
            .co_o(rip[i+1])
        );
    end

    // stage 2: decimal carry from binary carry or a result of 10..15
    always_comb dcarry = rip[DIGIT_W] | (bsum[3] & (bsum[2] | bsum[1]));

    // stage 3: add 0110; bit 0 is left as is
    bcd_half_cell u_fix1 (
        .x_i (bsum[1]),
        .y_i (dcarry),
        .s_o (digit_o[1]),
        .co_o(fix_c1)
    );

    bcd_full_cell u_fix2 (
        .x_i (bsum[2]),
        .y_i (dcarry),
        .z_i (fix_c1),
        .s_o (digit_o[2]),
        .co_o(fix_c2)
    );

    // top bit absorbs the correction carry; bit 0 passes through
    always_comb begin
        digit_o[0] = bsum[0];
        digit_o[3] = bsum[3] ^ fix_c2;
    end

    assign dcarry_o = dcarry;

    // invalid-code flag: a digit of 10..15 has bit 3 and bit 2 or bit 1 set
    always_comb bad_o = (a_i[3] & (a_i[2] | a_i[1])) | (b_i[3] & (b_i[2] | b_i[1]));
endmodule

// File: rtl/bcd_chain_adder.sv
// Module bcd_chain_adder
// Multi-digit packed decimal adder built by chaining digit slices.
// Digit k sits in bits [4k+3:4k]. The optional output register uses a
// synchronous active-low reset.
// Assumes legal operand digits; the sum is undefined where a flag is set.
module bcd_chain_adder
    import bcd_pkg::*;
#(
    parameter int unsigned DIGITS  = 4,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DIGITS*DIGIT_W-1:0]   a_i,
    input  logic [DIGITS*DIGIT_W-1:0]   b_i,
    input  logic                        cin_i,
    output logic [DIGITS*DIGIT_W-1:0]   sum_o,
    output logic                        cout_o,
    output logic [DIGITS-1:0]           bad_digit_o
);
    localparam int unsigned WORD_W = DIGITS * DIGIT_W;

    logic [DIGITS:0]     carry;
    logic [WORD_W-1:0]   sum_c;
    logic [DIGITS-1:0]   bad_c;

    assign carry[0] = cin_i;

    // one slice per digit, carry chained upward
    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        bcd_digit_slice u_slice (
            .a_i     (a_i[g*DIGIT_W +: DIGIT_W]),
            .b_i     (b_i[g*DIGIT_W +: DIGIT_W]),
            .cin_i   (carry[g]),
            .digit_o (sum_c[g*DIGIT_W +: DIGIT_W]),
            .dcarry_o(carry[g+1]),
            .bad_o   (bad_c[g])
        );

        // independent per-digit reference for the checks below
        logic [DIGIT_W:0] ref_sum;
        logic [DIGIT_W:0] ref_fix;
        always_comb begin
            ref_sum = {1'b0, a_i[g*DIGIT_W +: DIGIT_W]} + {1'b0, b_i[g*DIGIT_W +: DIGIT_W]}
                    + {{DIGIT_W{1'b0}}, carry[g]};
            ref_fix = ref_sum + {1'b0, ADJUST};
        end

        AST_DCARRY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            !bad_c[g] |-> (carry[g+1] == (ref_sum > {1'b0, MAX_DIGIT}))); // R3
        AST_DIGIT_FIX: assert property (@(posedge clk) disable iff (!rst_n)
            !bad_c[g] |-> (sum_c[g*DIGIT_W +: DIGIT_W] ==
                (carry[g+1] ? ref_fix[DIGIT_W-1:0] : ref_sum[DIGIT_W-1:0]))); // R4
        AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (bad_c == '0) |-> (sum_c[g*DIGIT_W +: DIGIT_W] <= MAX_DIGIT)); // R2
        AST_BAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            bad_c[g] == ((a_i[g*DIGIT_W +: DIGIT_W] > MAX_DIGIT) ||
                         (b_i[g*DIGIT_W +: DIGIT_W] > MAX_DIGIT))); // R7
    end

    if (REG_OUT) begin : g_reg
        // capture result, cleared by synchronous reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sum_o       <= '0;
                cout_o      <= 1'b0;
                bad_digit_o <= '0;
            end else begin
                sum_o       <= sum_c;
                cout_o      <= carry[DIGITS];
                bad_digit_o <= bad_c;
            end
        end

        AST_RESET_CLEAR: assert property (@(posedge clk)
            !rst_n |=> (sum_o == '0 && !cout_o && bad_digit_o == '0)); // R1
    end else begin : g_comb
        // pass result straight to the ports
        always_comb begin
            sum_o       = sum_c;
            cout_o      = carry[DIGITS];
            bad_digit_o = bad_c;
        end
    end
endmodule

// File: tb/bcd_chain_adder_tb_top.sv
module bcd_chain_adder_tb_top;
    localparam int DIG = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a = '0, b = '0;
    logic        cin = 1'b0;
    logic [15:0] sum;
    logic        cout;
    logic [3:0]  bad;
    logic [3:0]  a1 = '0, b1 = '0;
    logic        c1 = 1'b0;
    logic [3:0]  s1;
    logic        co1;
    logic [0:0]  bad1;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bcd_chain_adder #(.DIGITS(DIG), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .cin_i(cin),
        .sum_o(sum), .cout_o(cout), .bad_digit_o(bad));

    bcd_chain_adder #(.DIGITS(1), .REG_OUT(1'b0)) dut1_i (
        .clk(clk), .rst_n(rst_n), .a_i(a1), .b_i(b1), .cin_i(c1),
        .sum_o(s1), .cout_o(co1), .bad_digit_o(bad1));

    // a(16) b(16) cin(1) expected sum(16) expected cout(1); digit 0 in bits [3:0] (R6)
    localparam logic [49:0] VEC [8] = '{
        {16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0},
        {16'h9999, 16'h0001, 1'b0, 16'h0000, 1'b1},
        {16'h9999, 16'h9999, 1'b1, 16'h9999, 1'b1},
        {16'h1234, 16'h5678, 1'b0, 16'h6912, 1'b0},
        {16'h0005, 16'h0005, 1'b0, 16'h0010, 1'b0},
        {16'h0009, 16'h0000, 1'b1, 16'h0010, 1'b0},
        {16'h4999, 16'h5000, 1'b1, 16'h0000, 1'b1},
        {16'h0808, 16'h0707, 1'b0, 16'h1515, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int to_int(input logic [15:0] v);
        int r = 0;
        for (int k = 3; k >= 0; k--) r = r * 10 + int'(v[4*k +: 4]);
        return r;
    endfunction

    function automatic logic [15:0] to_bcd(input int v);
        logic [15:0] r;
        int t = v;
        for (int k = 0; k < 4; k++) begin
            r[4*k +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    // drive at a falling edge, result read one full cycle later
    task automatic apply(input logic [15:0] av, input logic [15:0] bv, input logic cv);
        @(negedge clk);
        a = av; b = bv; cin = cv;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] ra, rb;
        logic        rc;
        int          s;
        a = 16'h1234; b = 16'h4321; cin = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset clears registered outputs despite live inputs
        chk(sum == 16'h0 && !cout && bad == 4'h0, "R1 reset", {15'h0, cout, sum}, 32'h0);
        rst_n = 1'b1;

        // table walk (R5, R6, R2, R3, R4)
        foreach (VEC[i]) begin
            apply(VEC[i][49:34], VEC[i][33:18], VEC[i][17]);
            chk(sum == VEC[i][16:1] && cout == VEC[i][0], "R5 table",
                {15'h0, cout, sum}, {15'h0, VEC[i][0], VEC[i][16:1]});
        end

        // R8: latency of one register stage
        @(negedge clk);
        a = 16'h0001; b = 16'h0002; cin = 1'b0;
        #1;
        chk(sum == 16'h1515, "R8 hold before edge", {16'h0, sum}, {16'h0, 16'h1515});
        @(posedge clk);
        @(negedge clk);
        chk(sum == 16'h0003, "R8 update after edge", {16'h0, sum}, {16'h0, 16'h0003});

        // R7: invalid digit flag on digit 1 of a and digit 3 of b
        apply(16'h00A0, 16'hF000, 1'b0);
        chk(bad == 4'b1010, "R7 flag", {28'h0, bad}, 32'h0000000A);
        apply(16'h0999, 16'h9000, 1'b0);
        chk(bad == 4'b0000, "R7 legal nines", {28'h0, bad}, 32'h0);

        // R5: random valid operands against integer decimal addition
        for (int n = 0; n < 300; n++) begin
            for (int k = 0; k < 4; k++) begin
                ra[4*k +: 4] = 4'($urandom % 10);
                rb[4*k +: 4] = 4'($urandom % 10);
            end
            rc = 1'($urandom % 2);
            apply(ra, rb, rc);
            s = to_int(ra) + to_int(rb) + int'(rc);
            chk(sum == to_bcd(s % 10000) && cout == (s >= 10000) && sum[15:12] <= 4'd9,
                "R5 random", {15'h0, cout, sum}, {15'h0, 1'(s >= 10000), to_bcd(s % 10000)});
        end

        // exhaustive single digit, combinational variant (R2 R3 R4 R7 R8)
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                for (int z = 0; z < 2; z++) begin
                    a1 = 4'(x); b1 = 4'(y); c1 = 1'(z);
                    #1;
                    chk(bad1[0] == (x > 9 || y > 9), "R7 exhaustive", {31'h0, bad1[0]},
                        {31'h0, 1'(x > 9 || y > 9)});
                    if (x <= 9 && y <= 9) begin
                        s = x + y + z;
                        chk(s1 == 4'(s % 10) && co1 == (s > 9), "R3 R4 exhaustive",
                            {27'h0, co1, s1}, {27'h0, 1'(s > 9), 4'(s % 10)});
                    end
                end
            end
        end

        // R1: reset again mid-run
        @(negedge clk);
        a = 16'h9999; b = 16'h9999; cin = 1'b1;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(sum == 16'h0 && !cout, "R1 reset mid-run", {15'h0, cout, sum}, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule